// File: doc/BRIEF.md
# Peripheral Select Sequencer

This block drives the peripheral-select pins around each serial transfer of a command queue and times the gaps on either side. An upstream queue walker presents one command at a time. A command carries a select pattern, a continue flag, a last-of-queue flag and two enables that choose between standard and programmed delays. The block puts the pattern on the pins and waits out the lead delay. It then pulses a start to the shift engine and waits for that engine's done pulse. After that it waits out the trailing delay, and finally either parks the pins on the idle pattern or keeps the command's pattern driven.

Keeping the pattern driven lets a chain of transfers reach one peripheral without deselecting it. When the next command has a different pattern, the pins switch from the old pattern straight to the new one, with no idle cycle between them. Lead delays are counted in system clocks. Trailing delays are either a fixed short gap or a multiple of 32 clocks.

Top module: `cs_seq_ctrl`

## Requirements
- R1: After reset, `pcs` equals `idle_sel`, `cmd_ready` is 1 and `xfer_start` is 0.
- R2: From the cycle after a command is accepted until its trailing delay ends, `pcs` equals that command's `cmd_sel`. Any bit combination is allowed, including several active bits for broadcast.
- R3: With `cmd_lead_en` = 0, `xfer_start` is seen high in the 4th cycle after acceptance (HALF_SCK = 4 clocks from pins valid to start).
- R4: With `cmd_lead_en` = 1, that distance is `lead_len` cycles, and a `lead_len` of 0 means 256. `xfer_start` is high for exactly one cycle per command.
- R5: With `cmd_trail_en` = 0, the trailing delay is 17 cycles. These are the cycles with `cmd_ready` low after the cycle in which `xfer_done` was sampled high.
- R6: With `cmd_trail_en` = 1, the trailing delay is 32 × `trail_len` cycles, and a `trail_len` of 0 means 256 × 32 = 8192.
- R7: With the continue flag at 0, `pcs` returns to `idle_sel` once the trailing delay ends. While the block is idle, `pcs` follows changes to `idle_sel`.
- R8: With the continue flag at 1 and the last flag at 0, `pcs` keeps the command's pattern after the trailing delay, and `idle_sel` has no effect. The next accepted command's pattern is driven directly, with no idle cycle in between.
- R9: With the last flag at 1, `pcs` returns to `idle_sel` after the trailing delay, whatever the continue flag says.
- R10: `cmd_ready` is 1 only while idle or holding. A `cmd_valid` presented while busy is ignored: it changes neither `pcs` nor `xfer_start` until `cmd_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_sel | input | SEL_W | Select pattern of the command |
| cmd_cont | input | 1 | Keep pattern driven after the transfer |
| cmd_last | input | 1 | Command is the end of a non-wrapping queue |
| cmd_lead_en | input | 1 | Use programmed lead delay |
| cmd_trail_en | input | 1 | Use programmed trailing delay |
| idle_sel | input | SEL_W | Pin values when no pattern is driven |
| lead_len | input | DLY_W | Programmed lead delay in clocks (0 = 256) |
| trail_len | input | DLY_W | Programmed trailing delay in 32-clock units (0 = 256) |
| xfer_start | output | 1 | One-cycle start to the shift engine |
| xfer_done | input | 1 | Shift engine finished |
| pcs | output | SEL_W | Peripheral-select pins |

## Verification
The end of the trailing delay and the arrival of the next command can fall together. The bench holds `cmd_valid` high with a new pattern, starting during the shift phase and continuing through the whole trailing delay. It judges that the pins keep the old pattern while busy, and that the first ready cycle still shows the old pattern rather than the idle one. The new pattern must appear one cycle later, with `cmd_ready` low again. A second coincidence is an `idle_sel` change while the block is holding a pattern; the bench checks that this change never reaches the pins.

// File: rtl/cs_seq_pkg.sv
// Shared types for the peripheral select sequencer.
package cs_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // pins at idle values, ready
        ST_LEAD,   // pattern driven, lead delay running
        ST_SHIFT,  // shift engine busy
        ST_TRAIL,  // trailing delay running
        ST_HOLD    // pattern kept driven, ready
    } cs_state_t;
endpackage

// File: rtl/cs_delay_calc.sv
// Converts delay enables and fields into clock counts.
// Assumes HALF_SCK >= 1 and STD_TRAIL >= 1; a field of 0 encodes 2**DLY_W.
module cs_delay_calc #(
    parameter int DLY_W      = 8,
    parameter int CNT_W      = 14,
    parameter int HALF_SCK   = 4,
    parameter int STD_TRAIL  = 17,
    parameter int TRAIL_UNIT = 32
) (
    input  logic             lead_en,
    input  logic [DLY_W-1:0] lead_len,
    input  logic             trail_en,
    input  logic [DLY_W-1:0] trail_len,
    output logic [CNT_W-1:0] lead_cycles,
    output logic [CNT_W-1:0] trail_cycles
);
    localparam logic [CNT_W-1:0] FULL_FIELD = CNT_W'(1 << DLY_W);
    localparam logic [CNT_W-1:0] UNIT       = CNT_W'(TRAIL_UNIT);

    logic [CNT_W-1:0] lead_field, trail_field;

    // Expand zero fields to their full-scale meaning.
    always_comb begin
        lead_field  = (lead_len  == '0) ? FULL_FIELD : CNT_W'(lead_len);
        trail_field = (trail_len == '0) ? FULL_FIELD : CNT_W'(trail_len);
    end

    // Pick standard or programmed length for each delay.
    always_comb begin
        lead_cycles  = lead_en  ? lead_field : CNT_W'(HALF_SCK);
        trail_cycles = trail_en ? (trail_field * UNIT) : CNT_W'(STD_TRAIL);
    end
endmodule

// File: rtl/cs_delay_cnt.sv
// Down-counter for one delay phase. Loaded with N >= 1; 'expired'
// is high in the N-th cycle after the load edge.
module cs_delay_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on request, else count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Last cycle of the loaded delay.
    always_comb expired = (cnt == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R6
endmodule

// File: rtl/cs_pin_mux.sv
// Chooses, per pin, between the held pattern and the idle value.
module cs_pin_mux #(
    parameter int SEL_W = 4
) (
    input  logic             drive,
    input  logic [SEL_W-1:0] held_sel,
    input  logic [SEL_W-1:0] idle_sel,
    output logic [SEL_W-1:0] pins
);
    for (genvar i = 0; i < SEL_W; i++) begin : g_pin
        // One select pin: pattern while driving, idle value otherwise.
        always_comb pins[i] = drive ? held_sel[i] : idle_sel[i];
    end
endmodule

// File: rtl/cs_seq_ctrl.sv
// Peripheral select sequencer: accept command, drive pattern, lead
// delay, start pulse, wait done, trailing delay, then hold or release.
// Assumes xfer_done arrives only after xfer_start and that the
// programmed fields stay stable while their delay runs.
module cs_seq_ctrl #(
    parameter int SEL_W      = 4,
    parameter int DLY_W      = 8,
    parameter int HALF_SCK   = 4,
    parameter int STD_TRAIL  = 17,
    parameter int TRAIL_UNIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             cmd_cont,
    input  logic             cmd_last,
    input  logic             cmd_lead_en,
    input  logic             cmd_trail_en,
    input  logic [SEL_W-1:0] idle_sel,
    input  logic [DLY_W-1:0] lead_len,
    input  logic [DLY_W-1:0] trail_len,
    output logic             xfer_start,
    input  logic             xfer_done,
    output logic [SEL_W-1:0] pcs
);
    import cs_seq_pkg::*;

    localparam int CNT_W = $clog2(TRAIL_UNIT * (1 << DLY_W) + 1);

    cs_state_t        state;
    logic [SEL_W-1:0] cur_sel;
    logic             cur_cont, cur_last, cur_trail_en;
    logic             accept, done_seen, expired, cnt_load;
    logic [CNT_W-1:0] lead_cycles, trail_cycles, cnt_val;

    // Handshake: ready while idle or holding.
    always_comb begin
        cmd_ready = (state == ST_IDLE) || (state == ST_HOLD);
        accept    = cmd_valid && cmd_ready;
        done_seen = (state == ST_SHIFT) && xfer_done;
    end

    cs_delay_calc #(
        .DLY_W(DLY_W), .CNT_W(CNT_W), .HALF_SCK(HALF_SCK),
        .STD_TRAIL(STD_TRAIL), .TRAIL_UNIT(TRAIL_UNIT)
    ) u_calc (
        .lead_en     (cmd_lead_en),
        .lead_len    (lead_len),
        .trail_en    (cur_trail_en),
        .trail_len   (trail_len),
        .lead_cycles (lead_cycles),
        .trail_cycles(trail_cycles)
    );

    // Counter load: lead length on accept, trailing length on done.
    always_comb begin
        cnt_load = accept || done_seen;
        cnt_val  = accept ? lead_cycles : trail_cycles;
    end

    cs_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .expired (expired)
    );

    // Capture the command's own fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel      <= '0;
            cur_cont     <= 1'b0;
            cur_last     <= 1'b0;
            cur_trail_en <= 1'b0;
        end else if (accept) begin
            cur_sel      <= cmd_sel;
            cur_cont     <= cmd_cont;
            cur_last     <= cmd_last;
            cur_trail_en <= cmd_trail_en;
        end
    end

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE, ST_HOLD: if (accept)    state <= ST_LEAD;
                ST_LEAD:          if (expired)   state <= ST_SHIFT;
                ST_SHIFT:         if (xfer_done) state <= ST_TRAIL;
                ST_TRAIL: if (expired)
                    state <= (cur_cont && !cur_last) ? ST_HOLD : ST_IDLE;
                default:          state <= ST_IDLE;
            endcase
        end
    end

    // Start pulse in the final lead-delay cycle.
    always_comb xfer_start = (state == ST_LEAD) && expired;

    cs_pin_mux #(.SEL_W(SEL_W)) u_mux (
        .drive   (state != ST_IDLE),
        .held_sel(cur_sel),
        .idle_sel(idle_sel),
        .pins    (pcs)
    );

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R4
    AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE && !$past(accept))
        |-> $stable(pcs)); // R2
    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_ready) && cur_last) |-> (pcs == idle_sel)); // R9
    AST_READY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !xfer_start); // R10
endmodule

// File: tb/cs_seq_ctrl_tb.sv
module cs_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_cont = 1'b0, cmd_last = 1'b0;
    logic       cmd_lead_en = 1'b0, cmd_trail_en = 1'b0, xfer_done = 1'b0;
    logic [3:0] cmd_sel = 4'h0, idle_sel = 4'hF;
    logic [7:0] lead_len = 8'd1, trail_len = 8'd1;
    logic       cmd_ready, xfer_start;
    logic [3:0] pcs;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    cs_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sel(cmd_sel), .cmd_cont(cmd_cont), .cmd_last(cmd_last),
        .cmd_lead_en(cmd_lead_en), .cmd_trail_en(cmd_trail_en),
        .idle_sel(idle_sel), .lead_len(lead_len), .trail_len(trail_len),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .pcs(pcs)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for start, return cycles since accept (accept negedge = 1).
    task automatic wait_start(output int c);
        c = 1;
        while (!xfer_start && c < 400) begin
            @(negedge clk);
            c++;
        end
    endtask

    // Pulse done, count trailing cycles, checking the pattern holds.
    task automatic finish_xfer(input logic [3:0] sel, output int c, output int bad);
        repeat (2) @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        c = 0;
        bad = 0;
        while (!cmd_ready && c < 9000) begin
            if (pcs != sel) bad++;
            c++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [3:0] sel, input logic cont, input logic last,
                           input logic len, input logic [7:0] lv,
                           input logic ten, input logic [7:0] tv,
                           input int exp_lead, input int exp_trail,
                           input logic [3:0] exp_after,
                           input string lreq, input string treq, input string areq);
        int c, bad;
        chk(cmd_ready == 1'b1, "R10 ready before command", cmd_ready, 1);
        cmd_sel = sel; cmd_cont = cont; cmd_last = last;
        cmd_lead_en = len; lead_len = lv; cmd_trail_en = ten; trail_len = tv;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(pcs == sel, "R2 pattern on accept", pcs, sel);
        wait_start(c);
        chk(c == exp_lead, lreq, c, exp_lead);
        @(negedge clk);
        chk(xfer_start == 1'b0, "R4 single-cycle start", xfer_start, 0);
        finish_xfer(sel, c, bad);
        chk(bad == 0, "R2 pattern through trailing delay", bad, 0);
        chk(c == exp_trail, treq, c, exp_trail);
        chk(pcs == exp_after, areq, pcs, exp_after);
    endtask

    task automatic t_reset();
        chk(pcs == 4'hF, "R1 reset pins", pcs, 15);
        chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
        chk(xfer_start == 1'b0, "R1 reset start", xfer_start, 0);
    endtask

    task automatic t_basic();
        run_cmd(4'b0001, 0, 0, 0, 8'd9, 0, 8'd3, 4, 17, 4'hF,
                "R3 half-period lead", "R5 standard trail", "R7 release to idle");
        idle_sel = 4'hA;
        @(negedge clk);
        chk(pcs == 4'hA, "R7 idle follows idle_sel", pcs, 10);
        idle_sel = 4'hF;
        @(negedge clk);
    endtask

    task automatic t_programmed();
        run_cmd(4'b0110, 0, 0, 1, 8'd9, 1, 8'd2, 9, 64, 4'hF,
                "R4 programmed lead", "R6 programmed trail", "R7 release to idle");
        run_cmd(4'b1111, 0, 0, 1, 8'd0, 1, 8'd0, 256, 8192, 4'hF,
                "R4 lead zero means 256", "R6 trail zero means 8192", "R7 release to idle");
    endtask

    task automatic t_continue();
        run_cmd(4'h5, 1, 0, 0, 8'd1, 0, 8'd1, 4, 17, 4'h5,
                "R3 lead", "R5 trail", "R8 hold pattern");
        idle_sel = 4'h2;
        repeat (3) @(negedge clk);
        chk(pcs == 4'h5, "R8 idle_sel ignored while holding", pcs, 5);
        run_cmd(4'h5, 1, 0, 1, 8'd2, 0, 8'd1, 2, 17, 4'h5,
                "R4 lead", "R5 trail", "R8 same pattern kept");
        run_cmd(4'hC, 1, 1, 0, 8'd1, 0, 8'd1, 4, 17, 4'h2,
                "R3 lead", "R5 trail", "R9 last returns to idle");
        idle_sel = 4'hF;
        @(negedge clk);
    endtask

    // Command waiting while busy and colliding with end of trailing delay.
    task automatic t_overlap();
        int c, bad;
        run_cmd(4'h3, 1, 0, 0, 8'd1, 0, 8'd1, 4, 17, 4'h3,
                "R3 lead", "R5 trail", "R8 hold pattern");
        cmd_sel = 4'h9; cmd_cont = 1'b1; cmd_last = 1'b0;
        cmd_lead_en = 1'b0; cmd_trail_en = 1'b0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(pcs == 4'h9, "R8 direct switch to new pattern", pcs, 9);
        wait_start(c);
        @(negedge clk);
        cmd_sel = 4'h6; cmd_cont = 1'b0; cmd_valid = 1'b1;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pcs != 4'h9 || xfer_start) bad++;
        end
        chk(bad == 0, "R10 command ignored while busy", bad, 0);
        finish_xfer(4'h9, c, bad);
        chk(bad == 0, "R10 pattern kept while command waits", bad, 0);
        chk(c == 17, "R5 trail with command waiting", c, 17);
        chk(pcs == 4'h9, "R8 no idle cycle before next command", pcs, 9);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(pcs == 4'h6, "R8 next pattern driven", pcs, 6);
        chk(cmd_ready == 1'b0, "R10 waiting command accepted", cmd_ready, 0);
        wait_start(c);
        chk(c == 4, "R3 lead of queued command", c, 4);
        @(negedge clk);
        finish_xfer(4'h6, c, bad);
        chk(pcs == 4'hF, "R7 release after queued command", pcs, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_programmed();
        t_continue();
        t_overlap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule